// File: doc/BRIEF.md
# Command and Response Mailbox

This block gives a host one byte-wide mailbox address through which commands go in and responses come out. Every host write to the mailbox address adds one byte to a command buffer. Every host read from that address returns the next byte of the current response. A second, write-only address clears the command side and rewinds the response stream, so a host that was interrupted part-way through a response can read it again from its first byte.

A command block starts with an opcode byte. The byte after it gives the total block length, and two checksum bytes end the block. As each byte arrives the block updates a CRC-16 over it. When the last byte lands, the block compares the received checksum with the computed one. If they match, the block holds the opcode, the length and a random-access view of the stored bytes for a downstream executor until that executor reports completion. The executor pushes response bytes into the response buffer while the command runs. A read-only status address reports execution, response validity, the two error kinds and reception progress.

Top module: `mbox_cmdrsp`

## Requirements
- R1: While a command is being executed, the executor sees each byte written to the mailbox address 0xFE00 at its position in arrival order: `cmd_op_o` is byte 0 and `cmd_byte_o` is the byte at index `cmd_idx_i`.
- R2: Byte 1 of a block gives the total block length L, counting the opcode, the length byte itself, the operands and the two checksum bytes. If L is below 4 or above the buffer depth (64), the command error is set and further mailbox writes are dropped until a clear. L = 64 is accepted.
- R3: The checksum is a CRC-16 with polynomial 0x8005, initial value 0x0000 and no reflection, computed over bytes 0 to L-3. Bytes L-2 and L-1 carry the checksum, high byte first. When they match, `cmd_vld_o` rises in the cycle after the final byte is written and stays high until `rsp_done_i`.
- R4: When the checksum does not match, status bit 2 (checksum error) is set and `cmd_vld_o` stays low. Further mailbox writes are dropped until a clear.
- R5: A read of 0xFE00 returns response bytes in the order the executor pushed them. The data appears on `bus_rdata_o` in the cycle after the read.
- R6: A read of 0xFE00 when no response is valid, or after the last valid byte has been read, returns 0xFF and leaves the read pointer where it is.
- R7: A write of any value to 0xFFE0 rewinds the response read pointer to the first byte. When no command is executing, the same write also empties the command buffer and clears both error bits.
- R8: A read of 0xFFF0 returns the status byte: bit 0 executing, bit 1 response valid, bit 2 checksum error, bit 3 command error, bit 4 command reception in progress, bits 7:5 zero.
- R9: A mailbox write during execution is dropped and sets the command error. The presented opcode, length and bytes are unchanged.
- R10: `rsp_done_i` during execution ends it and marks the response valid. Issuing a new command empties the response and clears its valid flag.
- R11: After reset, `cmd_vld_o` and `bus_rdata_o` are 0 and the status byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_vld_i | input | 1 | Host access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Host byte address |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Read data, registered, valid the cycle after a read |
| cmd_vld_o | output | 1 | Verified command held for the executor |
| cmd_op_o | output | 8 | Opcode byte |
| cmd_len_o | output | 8 | Total block length |
| cmd_idx_i | input | 6 | Byte index for the executor's view |
| cmd_byte_o | output | 8 | Stored byte at `cmd_idx_i` |
| rsp_we_i | input | 1 | Executor pushes one response byte |
| rsp_byte_i | input | 8 | Response byte |
| rsp_done_i | input | 1 | Executor finished; response becomes valid |

## Verification
Each host access takes a single cycle. Read data is registered, so it appears one cycle after the read strobe. `cmd_vld_o`, the status bits and the response pointer all change at the same edge that captures the write or read that caused the change. The bench drives every strobe for one cycle starting at a falling edge. It samples results at the next falling edge, which is the first point where the registered effect is visible. Combinational executor outputs are sampled one time step after `cmd_idx_i` is driven.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef struct packed {
    logic [2:0] rsv;
    logic       rx;
    logic       cmd_err;
    logic       crc_err;
    logic       rsp_vld;
    logic       busy;
  } stat_t;
endpackage

// File: rtl/mbox_crc_step.sv
module mbox_crc_step #(
  parameter logic [15:0] POLY = 16'h8005
) (
  input  logic [15:0] crc_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] s [9];
  assign s[0] = crc_i;
  for (genvar g = 0; g < 8; g++) begin : g_bit
    logic fb;
    assign fb       = s[g][15] ^ data_i[7-g];
    assign s[g+1]   = {s[g][14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
  end
  assign crc_o = s[8];
endmodule

// File: rtl/mbox_cmd_buf.sv
module mbox_cmd_buf #(
  parameter int          DEPTH = 64,
  parameter logic [15:0] POLY  = 16'h8005,
  localparam int         IW    = $clog2(DEPTH),
  localparam int         CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  input  logic          clr_i,
  input  logic          done_i,
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    byte_o,
  output logic [7:0]    op_o,
  output logic [7:0]    len_o,
  output logic          busy_o,
  output logic          issue_o,
  output logic          crc_err_o,
  output logic          cmd_err_o,
  output logic          rx_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] wcnt_q;
  logic [7:0]    len_q, wpos;
  logic [15:0]   crc_q, crc_nx;
  logic          busy_q, crc_err_q, cmd_err_q, lock_q;
  logic          accept, len_bad, in_crc, is_last, sum_ok;

  mbox_crc_step #(.POLY(POLY)) u_crc (.crc_i(crc_q), .data_i(wdata_i), .crc_o(crc_nx));

  assign wpos    = 8'(wcnt_q);
  assign accept  = wr_i & ~busy_q & ~clr_i & ~lock_q;
  assign len_bad = (wpos == 8'd1) && ((wdata_i < 8'd4) || (int'(wdata_i) > DEPTH));
  // bytes before the checksum feed the CRC; length unknown for first two
  assign in_crc  = (wpos < 8'd2) || (wpos < len_q - 8'd2);
  assign is_last = (wpos >= 8'd2) && (wpos == len_q - 8'd1);
  assign sum_ok  = ({mem_q[IW'(len_q - 8'd2)], wdata_i} == crc_q);
  assign issue_o = accept & is_last & sum_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (accept) begin
      mem_q[IW'(wcnt_q)] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q    <= '0;
      len_q     <= 8'h00;
      crc_q     <= 16'h0000;
      busy_q    <= 1'b0;
      crc_err_q <= 1'b0;
      cmd_err_q <= 1'b0;
      lock_q    <= 1'b0;
    end else if (busy_q) begin
      if (wr_i) cmd_err_q <= 1'b1;
      if (done_i) begin
        busy_q <= 1'b0;
        wcnt_q <= '0;
        len_q  <= 8'h00;
        crc_q  <= 16'h0000;
      end
    end else if (clr_i) begin
      wcnt_q    <= '0;
      len_q     <= 8'h00;
      crc_q     <= 16'h0000;
      crc_err_q <= 1'b0;
      cmd_err_q <= 1'b0;
      lock_q    <= 1'b0;
    end else if (accept) begin
      wcnt_q <= wcnt_q + 1'b1;
      if (in_crc) crc_q <= crc_nx;
      if (wpos == 8'd1) len_q <= wdata_i;
      if (len_bad) begin
        cmd_err_q <= 1'b1;
        lock_q    <= 1'b1;
      end
      if (is_last) begin
        if (sum_ok) busy_q <= 1'b1;
        else begin
          crc_err_q <= 1'b1;
          lock_q    <= 1'b1;
        end
      end
    end
  end

  assign byte_o    = mem_q[idx_i];
  assign op_o      = mem_q[0];
  assign len_o     = len_q;
  assign busy_o    = busy_q;
  assign crc_err_o = crc_err_q;
  assign cmd_err_o = cmd_err_q;
  assign rx_o      = (wcnt_q != '0) & ~busy_q & ~lock_q;
endmodule

// File: rtl/mbox_rsp_buf.sv
module mbox_rsp_buf #(
  parameter int  DEPTH = 64,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       push_i,
  input  logic [7:0] pdata_i,
  input  logic       fin_i,
  input  logic       rewind_i,
  input  logic       pop_i,
  output logic [7:0] head_o,
  output logic       vld_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] len_q, ptr_q;
  logic          vld_q, avail, wr_ok;

  assign avail  = vld_q && (ptr_q < len_q);
  assign wr_ok  = push_i && !start_i && (len_q < CW'(DEPTH));
  assign head_o = avail ? mem_q[IW'(ptr_q)] : 8'hFF;
  assign vld_o  = vld_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[IW'(len_q)] <= pdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      ptr_q <= '0;
      vld_q <= 1'b0;
    end else if (start_i) begin
      len_q <= '0;
      ptr_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (wr_ok) len_q <= len_q + 1'b1;
      if (fin_i) vld_q <= 1'b1;
      if (rewind_i) ptr_q <= '0;
      else if (pop_i && avail) ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/mbox_cmdrsp.sv
module mbox_cmdrsp #(
  parameter int          DEPTH     = 64,
  parameter int          RSP_DEPTH = 64,
  parameter int          AW        = 16,
  parameter logic [15:0] MBOX_ADDR = 16'hFE00,
  parameter logic [15:0] RST_ADDR  = 16'hFFE0,
  parameter logic [15:0] STAT_ADDR = 16'hFFF0,
  parameter logic [15:0] POLY      = 16'h8005,
  parameter int          IW        = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_vld_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  output logic          cmd_vld_o,
  output logic [7:0]    cmd_op_o,
  output logic [7:0]    cmd_len_o,
  input  logic [IW-1:0] cmd_idx_i,
  output logic [7:0]    cmd_byte_o,
  input  logic          rsp_we_i,
  input  logic [7:0]    rsp_byte_i,
  input  logic          rsp_done_i
);
  import mbox_pkg::*;

  logic          wr_mbox, wr_rst, rd_mbox, rd_stat, rd_any;
  logic          busy, issue, crc_err, cmd_err, rx, rsp_vld;
  logic [7:0]    head, rdata_q;
  stat_t         stat;

  assign wr_mbox = bus_vld_i &  bus_we_i & (bus_addr_i == AW'(MBOX_ADDR));
  assign wr_rst  = bus_vld_i &  bus_we_i & (bus_addr_i == AW'(RST_ADDR));
  assign rd_any  = bus_vld_i & ~bus_we_i;
  assign rd_mbox = rd_any & (bus_addr_i == AW'(MBOX_ADDR));
  assign rd_stat = rd_any & (bus_addr_i == AW'(STAT_ADDR));

  mbox_cmd_buf #(.DEPTH(DEPTH), .POLY(POLY)) u_cmd (
    .clk_i, .rst_ni,
    .wr_i(wr_mbox), .wdata_i(bus_wdata_i), .clr_i(wr_rst), .done_i(rsp_done_i),
    .idx_i(cmd_idx_i), .byte_o(cmd_byte_o), .op_o(cmd_op_o), .len_o(cmd_len_o),
    .busy_o(busy), .issue_o(issue), .crc_err_o(crc_err), .cmd_err_o(cmd_err), .rx_o(rx)
  );

  mbox_rsp_buf #(.DEPTH(RSP_DEPTH)) u_rsp (
    .clk_i, .rst_ni,
    .start_i(issue), .push_i(rsp_we_i & busy), .pdata_i(rsp_byte_i),
    .fin_i(rsp_done_i & busy), .rewind_i(wr_rst), .pop_i(rd_mbox),
    .head_o(head), .vld_o(rsp_vld)
  );

  always_comb begin
    stat         = '0;
    stat.busy    = busy;
    stat.rsp_vld = rsp_vld;
    stat.crc_err = crc_err;
    stat.cmd_err = cmd_err;
    stat.rx      = rx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= 8'h00;
    else if (rd_mbox) rdata_q <= head;
    else if (rd_stat) rdata_q <= stat;
    else if (rd_any)  rdata_q <= 8'h00;
  end

  assign bus_rdata_o = rdata_q;
  assign cmd_vld_o   = busy;
endmodule

// File: rtl/mbox_cmdrsp_chk.sv
module mbox_cmdrsp_chk #(
  parameter int          AW        = 16,
  parameter logic [15:0] MBOX_ADDR = 16'hFE00,
  parameter logic [15:0] STAT_ADDR = 16'hFFF0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_vld_i,
  input logic          bus_we_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [7:0]    bus_rdata_o,
  input logic          cmd_vld_o,
  input logic [7:0]    cmd_op_o,
  input logic [7:0]    cmd_len_o,
  input logic          rsp_done_i,
  input logic          crc_err,
  input logic          rsp_vld
);
  logic rd_mbox, rd_stat;
  assign rd_mbox = bus_vld_i & ~bus_we_i & (bus_addr_i == AW'(MBOX_ADDR));
  assign rd_stat = bus_vld_i & ~bus_we_i & (bus_addr_i == AW'(STAT_ADDR));

  // R3
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o && !rsp_done_i |=> cmd_vld_o);

  // R9
  op_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o && !rsp_done_i |=> $stable(cmd_op_o) && $stable(cmd_len_o));

  // R4
  crc_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err |-> !cmd_vld_o);

  // R6
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mbox && !rsp_vld |=> bus_rdata_o == 8'hFF);

  // R8
  stat_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> bus_rdata_o[0] == $past(cmd_vld_o));

  // R10
  rsp_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_vld_o) |-> !rsp_vld);
endmodule

bind mbox_cmdrsp mbox_cmdrsp_chk #(.AW(AW), .MBOX_ADDR(MBOX_ADDR), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_vld_i(bus_vld_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .cmd_vld_o(cmd_vld_o),
  .cmd_op_o(cmd_op_o), .cmd_len_o(cmd_len_o), .rsp_done_i(rsp_done_i),
  .crc_err(crc_err), .rsp_vld(rsp_vld)
);

// File: tb/sim_mbox_cmdrsp.sv
module sim_mbox_cmdrsp;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] A_MBOX = 16'hFE00;
  localparam logic [15:0] A_RST  = 16'hFFE0;
  localparam logic [15:0] A_STAT = 16'hFFF0;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        bus_vld_i = 0, bus_we_i = 0;
  logic [15:0] bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0, bus_rdata_o;
  logic        cmd_vld_o;
  logic [7:0]  cmd_op_o, cmd_len_o, cmd_byte_o;
  logic [5:0]  cmd_idx_i = '0;
  logic        rsp_we_i = 0, rsp_done_i = 0;
  logic [7:0]  rsp_byte_i = '0;

  int n_tests = 0, n_fail = 0;
  logic [7:0] blk [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_cmdrsp u0 (
    .clk_i(clk), .rst_ni, .bus_vld_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .cmd_vld_o, .cmd_op_o, .cmd_len_o, .cmd_idx_i, .cmd_byte_o,
    .rsp_we_i, .rsp_byte_i, .rsp_done_i
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ blk[i][b];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
      end
    return c;
  endfunction

  task automatic seal(int n);
    logic [15:0] c = ref_crc(n - 2);
    blk[n-2] = c[15:8];
    blk[n-1] = c[7:0];
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_vld_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_vld_i = 0; bus_we_i = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_vld_i = 1; bus_we_i = 0; bus_addr_i = a;
    @(negedge clk);
    bus_vld_i = 0;
    d = bus_rdata_o;
  endtask

  task automatic send(int n);
    for (int i = 0; i < n; i++) wr(A_MBOX, blk[i]);
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); rsp_we_i = 1; rsp_byte_i = b;
    @(negedge clk); rsp_we_i = 0;
  endtask

  task automatic done();
    @(negedge clk); rsp_done_i = 1;
    @(negedge clk); rsp_done_i = 0;
  endtask

  task automatic peek(logic [5:0] i, output logic [7:0] b);
    cmd_idx_i = i; #1; b = cmd_byte_o;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R11 cmd_vld", 16'(cmd_vld_o), 16'h0);
    chk("R11 rdata", 16'(bus_rdata_o), 16'h00);
    rd(A_STAT, s);
    chk("R11 status", 16'(s), 16'h00);
  endtask

  task automatic t_good();
    logic [7:0] s, b;
    blk[0] = 8'h31; blk[1] = 8'd6; blk[2] = 8'hA5; blk[3] = 8'h5A; seal(6);
    send(5);
    chk("R3 not before last", 16'(cmd_vld_o), 16'h0);
    rd(A_STAT, s);
    chk("R8 rx bit", 16'(s), 16'h10);
    wr(A_MBOX, blk[5]);
    chk("R3 cmd_vld", 16'(cmd_vld_o), 16'h1);
    chk("R1 opcode", 16'(cmd_op_o), 16'h31);
    chk("R2 length", 16'(cmd_len_o), 16'd6);
    peek(6'd2, b); chk("R1 byte2", 16'(b), 16'hA5);
    peek(6'd3, b); chk("R1 byte3", 16'(b), 16'h5A);
    rd(A_STAT, s);
    chk("R8 busy", 16'(s), 16'h01);
  endtask

  task automatic t_busy_write();
    logic [7:0] s, b;
    wr(A_MBOX, 8'h77);
    peek(6'd0, b); chk("R9 byte0 kept", 16'(b), 16'h31);
    peek(6'd2, b); chk("R9 byte2 kept", 16'(b), 16'hA5);
    chk("R9 still valid", 16'(cmd_vld_o), 16'h1);
    rd(A_STAT, s);
    chk("R9 cmd_err", 16'(s), 16'h09);
  endtask

  task automatic t_response();
    logic [7:0] s, d;
    push(8'h11); push(8'h22); push(8'h33);
    rd(A_MBOX, d); chk("R6 not yet valid", 16'(d), 16'hFF);
    done();
    chk("R10 done clears", 16'(cmd_vld_o), 16'h0);
    rd(A_STAT, s); chk("R10 rsp valid", 16'(s), 16'h0A);
    rd(A_MBOX, d); chk("R5 rsp0", 16'(d), 16'h11);
    rd(A_MBOX, d); chk("R5 rsp1", 16'(d), 16'h22);
    rd(A_MBOX, d); chk("R5 rsp2", 16'(d), 16'h33);
    rd(A_MBOX, d); chk("R6 past end", 16'(d), 16'hFF);
    rd(A_MBOX, d); chk("R6 past end again", 16'(d), 16'hFF);
    wr(A_RST, 8'h5C);
    rd(A_MBOX, d); chk("R7 rewind", 16'(d), 16'h11);
    rd(A_STAT, s); chk("R7 errors cleared", 16'(s), 16'h02);
    rd(A_MBOX, d); chk("R7 continues", 16'(d), 16'h22);
    wr(A_RST, 8'h00);
  endtask

  task automatic t_rsp_cleared();
    logic [7:0] s, d;
    blk[0] = 8'h40; blk[1] = 8'd4; seal(4);
    send(4);
    chk("R3 min length issue", 16'(cmd_vld_o), 16'h1);
    rd(A_STAT, s); chk("R10 rsp cleared", 16'(s), 16'h01);
    rd(A_MBOX, d); chk("R10 no old rsp", 16'(d), 16'hFF);
    done();
    rd(A_MBOX, d); chk("R6 empty rsp", 16'(d), 16'hFF);
  endtask

  task automatic t_bad_crc();
    logic [7:0] s;
    blk[0] = 8'h22; blk[1] = 8'd5; blk[2] = 8'h9C; seal(5);
    blk[4] = blk[4] ^ 8'h01;
    send(5);
    chk("R4 no issue", 16'(cmd_vld_o), 16'h0);
    rd(A_STAT, s); chk("R4 crc_err", 16'(s), 16'h06);
    blk[0] = 8'h22; blk[1] = 8'd5; blk[2] = 8'h9C; seal(5);
    send(5);
    chk("R4 locked", 16'(cmd_vld_o), 16'h0);
    rd(A_STAT, s); chk("R4 still locked", 16'(s), 16'h06);
    wr(A_RST, 8'hFF);
    rd(A_STAT, s); chk("R7 clear", 16'(s), 16'h02);
    send(5);
    chk("R7 accepts after clear", 16'(cmd_vld_o), 16'h1);
    done();
    wr(A_RST, 8'h00);
  endtask

  task automatic t_bad_len();
    logic [7:0] s, b;
    wr(A_MBOX, 8'h10); wr(A_MBOX, 8'd3);
    rd(A_STAT, s); chk("R2 short length", 16'(s), 16'h0A);
    wr(A_RST, 8'h00);
    wr(A_MBOX, 8'h10); wr(A_MBOX, 8'd65);
    rd(A_STAT, s); chk("R2 long length", 16'(s), 16'h0A);
    wr(A_RST, 8'h00);
    blk[0] = 8'h7E; blk[1] = 8'd64;
    for (int i = 2; i < 62; i++) blk[i] = 8'(i * 3 + 1);
    seal(64);
    send(64);
    chk("R2 max length", 16'(cmd_vld_o), 16'h1);
    chk("R2 max len out", 16'(cmd_len_o), 16'd64);
    peek(6'd61, b); chk("R1 byte61", 16'(b), 16'(blk[61]));
    done();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    t_reset();
    t_good();
    t_busy_write();
    t_response();
    t_rsp_cleared();
    t_bad_crc();
    t_bad_len();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule